// File: doc/BRIEF.md
# 16-bit Register Byte-Access Bridge

This block sits between an 8-bit processor bus and a group of four 16-bit timer registers: a counter, two compare registers and a capture register. The bus can move only one byte per access. To keep every 16-bit access atomic, the block holds a single shared high byte. Every register uses this same byte.

To write a register, software writes the high byte first and the low byte second. The high-byte write lands only in the shared byte. The low-byte write then presents the whole 16-bit word to the peripheral, together with a one-cycle commit strobe for that register.

To read the counter or the capture register, software reads the low byte first and the high byte second. The low-byte read freezes the register's high byte of that same cycle into the shared byte. The high-byte read then returns the frozen value. The compare registers change only when software writes them, so their high bytes are read live and their reads leave the shared byte alone.

Top module: `wide_reg_byte_bridge`

## Requirements
- R1: After reset the shared high byte is 0x00. It has no address of its own and is seen only through the counter and capture high-byte addresses.
- R2: A write to any high-byte address (odd address 1, 3, 5 or 7) loads the written byte into the shared byte and raises no commit strobe.
- R3: A write to a low-byte address raises that register's commit strobe for the same cycle only. While the strobe is high, the write word equals {shared byte, written byte}. The register is chosen by address bits [2:1]: 0 = counter, 1 = compare 0, 2 = compare 1, 3 = capture.
- R4: A read of the counter low byte (address 0) or the capture low byte (address 6) returns the live low byte. At the clock edge that ends the read, the live high byte of that same cycle is copied into the shared byte.
- R5: A read of the counter high byte (address 1) or the capture high byte (address 7) returns the shared byte, not the live high byte.
- R6: A read of a compare high byte (address 3 or 5) returns that register's live high byte. A read of either compare byte (address 2, 3, 4 or 5) leaves the shared byte unchanged.
- R7: The shared byte serves all registers. A high write to one register, then a counter or capture low read, then a low write commits the snapshotted byte, not the byte that was written.
- R8: Addresses 8 and above read as 0x00. Writes to them raise no strobe and leave the shared byte unchanged. Read and write strobes are never active in the same cycle.
- R9: A low write does not alter the shared byte, so consecutive low writes reuse the same high byte.
- R10: Read data is 0x00 in any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of the read strobe |
| cnt_val | input | 16 | Live counter value |
| cmp0_val | input | 16 | Live compare 0 value |
| cmp1_val | input | 16 | Live compare 1 value |
| cap_val | input | 16 | Live capture value |
| wr_value | output | 16 | Word to commit, meaningful while a strobe is high |
| cnt_commit | output | 1 | Counter commit strobe |
| cmp0_commit | output | 1 | Compare 0 commit strobe |
| cmp1_commit | output | 1 | Compare 1 commit strobe |
| cap_commit | output | 1 | Capture commit strobe |

## Verification
Two things can fall in the same cycle: a low-byte snapshot read of the counter, and a change of the live counter value at the edge that closes that read. The bench runs a free counter across a carry from 0x00FF to 0x0100 and reads the low byte in the 0x00FF cycle. It then requires the following high-byte read to return 0x00, the value from before the carry. A second run of the same kind expects 0x01 once the snapshot is taken after the carry. The interleaved sequence of R7 is judged by the word presented with the counter commit strobe.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int NUM_REGS = 4;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_CMP0 = 2'd1,
    SEL_CMP1 = 2'd2,
    SEL_CAP  = 2'd3
  } reg_sel_e;

  // registers whose high byte is frozen by a low-byte read
  function automatic logic is_snapshot_reg(input reg_sel_e sel);
    return (sel == SEL_CNT) || (sel == SEL_CAP);
  endfunction

  function automatic logic [WORD_W-1:0] join_word(input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input logic hi);
    return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output reg_sel_e          sel,
  output logic              is_hi,
  output logic              mapped,
  output logic              hi_wr_evt,
  output logic              lo_wr_evt,
  output logic              snap_evt
);
  localparam int MAP_BYTES = 2 * NUM_REGS;

  always_comb begin
    sel       = reg_sel_e'(addr[2:1]);
    is_hi     = addr[0];
    mapped    = (int'(addr) < MAP_BYTES);
    hi_wr_evt = wr && mapped && is_hi;
    lo_wr_evt = wr && mapped && !is_hi;
    snap_evt  = rd && mapped && !is_hi && is_snapshot_reg(sel);
  end
endmodule

// File: rtl/bb_hold.sv
module bb_hold
  import bb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              snap_en,
  input  logic [BYTE_W-1:0] snap_byte,
  output logic [BYTE_W-1:0] hold_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       hold_q <= '0;
    else if (load_en) hold_q <= load_byte;
    else if (snap_en) hold_q <= snap_byte;
  end

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en || snap_en) |=> $stable(hold_q));
  assert_hold_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> hold_q == $past(load_byte));
  assert_hold_snap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_en && !load_en) |=> hold_q == $past(snap_byte));
endmodule

// File: rtl/bb_rdmux.sv
module bb_rdmux
  import bb_pkg::*;
(
  input  logic              rd,
  input  reg_sel_e          sel,
  input  logic              is_hi,
  input  logic              mapped,
  input  logic [WORD_W-1:0] vals [NUM_REGS],
  input  logic [BYTE_W-1:0] hold_q,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd && mapped) begin
      if (is_hi && is_snapshot_reg(sel)) rdata = hold_q;
      else                               rdata = pick_byte(vals[sel], is_hi);
    end
  end
endmodule

// File: rtl/wide_reg_byte_bridge.sv
module wide_reg_byte_bridge
  import bb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [15:0]       cnt_val,
  input  logic [15:0]       cmp0_val,
  input  logic [15:0]       cmp1_val,
  input  logic [15:0]       cap_val,
  output logic [15:0]       wr_value,
  output logic              cnt_commit,
  output logic              cmp0_commit,
  output logic              cmp1_commit,
  output logic              cap_commit
);
  reg_sel_e          sel;
  logic              is_hi, mapped, hi_wr_evt, lo_wr_evt, snap_evt;
  logic [BYTE_W-1:0] hold_q;
  logic [WORD_W-1:0] vals [NUM_REGS];
  logic [NUM_REGS-1:0] commit_vec;

  assign vals[SEL_CNT]  = cnt_val;
  assign vals[SEL_CMP0] = cmp0_val;
  assign vals[SEL_CMP1] = cmp1_val;
  assign vals[SEL_CAP]  = cap_val;

  bb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .sel(sel), .is_hi(is_hi),
    .mapped(mapped), .hi_wr_evt(hi_wr_evt), .lo_wr_evt(lo_wr_evt), .snap_evt(snap_evt)
  );

  bb_hold u_hold (
    .clk(clk), .rst_n(rst_n), .load_en(hi_wr_evt), .load_byte(bus_wdata),
    .snap_en(snap_evt), .snap_byte(pick_byte(vals[sel], 1'b1)), .hold_q(hold_q)
  );

  bb_rdmux u_rd (
    .rd(bus_rd), .sel(sel), .is_hi(is_hi), .mapped(mapped), .vals(vals),
    .hold_q(hold_q), .rdata(bus_rdata)
  );

  assign wr_value = join_word(hold_q, bus_wdata);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_commit
    assign commit_vec[g] = lo_wr_evt && (int'(sel) == g);
  end

  assign cnt_commit  = commit_vec[SEL_CNT];
  assign cmp0_commit = commit_vec[SEL_CMP0];
  assign cmp1_commit = commit_vec[SEL_CMP1];
  assign cap_commit  = commit_vec[SEL_CAP];

  assert_rd_wr_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  assert_unmapped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mapped) |-> (bus_rdata == 8'h00 &&
                   !(cnt_commit || cmp0_commit || cmp1_commit || cap_commit)));
  assert_commit_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_commit, cmp0_commit, cmp1_commit, cap_commit}));
  assert_hi_write_no_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[0]) |->
      !(cnt_commit || cmp0_commit || cmp1_commit || cap_commit));
  assert_commit_high_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hi_wr_evt) && (cnt_commit || cmp0_commit || cmp1_commit || cap_commit))
      |-> wr_value[15:8] == $past(bus_wdata));
  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 8'h00);
endmodule

// File: tb/sim_wide_reg_byte_bridge.sv
module sim_wide_reg_byte_bridge;
  localparam int CLK_T = 10;
  localparam logic [1:0] OP_WR = 2'd1, OP_RD = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [7:0]  wd;
    logic [7:0]  erd;
    logic [3:0]  ecm;  // {cap, cmp1, cmp0, cnt}
    logic [15:0] ewv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  // live values: counter A1B2, compare0 C3D4, compare1 E5F6, capture 0718
  localparam vec_t VECS [NV] = '{
    '{OP_WR, 4'd1, 8'h5A, 8'h00, 4'h0, 16'h0000, 4'd2},  // R2
    '{OP_WR, 4'd0, 8'h3C, 8'h00, 4'h1, 16'h5A3C, 4'd3},  // R3
    '{OP_WR, 4'd0, 8'h77, 8'h00, 4'h1, 16'h5A77, 4'd9},  // R9
    '{OP_RD, 4'd1, 8'h00, 8'h5A, 4'h0, 16'h0000, 4'd5},  // R5
    '{OP_RD, 4'd0, 8'h00, 8'hB2, 4'h0, 16'h0000, 4'd4},  // R4
    '{OP_RD, 4'd1, 8'h00, 8'hA1, 4'h0, 16'h0000, 4'd4},  // R4
    '{OP_RD, 4'd3, 8'h00, 8'hC3, 4'h0, 16'h0000, 4'd6},  // R6
    '{OP_RD, 4'd2, 8'h00, 8'hD4, 4'h0, 16'h0000, 4'd6},  // R6
    '{OP_RD, 4'd1, 8'h00, 8'hA1, 4'h0, 16'h0000, 4'd6},  // R6 shared byte kept
    '{OP_WR, 4'd5, 8'h99, 8'h00, 4'h0, 16'h0000, 4'd2},  // R2
    '{OP_WR, 4'd4, 8'h11, 8'h00, 4'h4, 16'h9911, 4'd3},  // R3
    '{OP_RD, 4'd5, 8'h00, 8'hE5, 4'h0, 16'h0000, 4'd6},  // R6
    '{OP_WR, 4'd1, 8'hAB, 8'h00, 4'h0, 16'h0000, 4'd7},  // R7 high write
    '{OP_RD, 4'd6, 8'h00, 8'h18, 4'h0, 16'h0000, 4'd7},  // R7 capture snapshot
    '{OP_WR, 4'd0, 8'hCD, 8'h00, 4'h1, 16'h07CD, 4'd7},  // R7 corrupted commit
    '{OP_WR, 4'd9, 8'hFF, 8'h00, 4'h0, 16'h0000, 4'd8},  // R8
    '{OP_RD, 4'd9, 8'h00, 8'h00, 4'h0, 16'h0000, 4'd8},  // R8
    '{OP_RD, 4'd7, 8'h00, 8'h07, 4'h0, 16'h0000, 4'd8},  // R8 shared byte kept
    '{OP_WR, 4'd7, 8'h21, 8'h00, 4'h0, 16'h0000, 4'd2},  // R2
    '{OP_WR, 4'd6, 8'h43, 8'h00, 4'h8, 16'h2143, 4'd3},  // R3
    '{OP_WR, 4'd3, 8'h66, 8'h00, 4'h0, 16'h0000, 4'd2},  // R2
    '{OP_WR, 4'd2, 8'h88, 8'h00, 4'h2, 16'h6688, 4'd3}   // R3
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [15:0] cnt_val, wr_value;
  logic cnt_commit, cmp0_commit, cmp1_commit, cap_commit;
  logic cnt_run = 1'b0;
  logic [15:0] run_cnt = 16'h00FE;
  int checks = 0, fails = 0;

  always #(CLK_T/2) clk = ~clk;
  always @(posedge clk) run_cnt <= cnt_run ? run_cnt + 16'd1 : 16'h00FE;
  assign cnt_val = cnt_run ? run_cnt : 16'hA1B2;

  wide_reg_byte_bridge u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_val(cnt_val),
    .cmp0_val(16'hC3D4), .cmp1_val(16'hE5F6), .cap_val(16'h0718),
    .wr_value(wr_value), .cnt_commit(cnt_commit), .cmp0_commit(cmp0_commit),
    .cmp1_commit(cmp1_commit), .cap_commit(cap_commit)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] o, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d;
    bus_wr = (o == OP_WR); bus_rd = (o == OP_RD);
    #(CLK_T/4);
  endtask

  function automatic logic [3:0] strobes();
    return {cap_commit, cmp1_commit, cmp0_commit, cnt_commit};
  endfunction

  function automatic string rtag(input logic [3:0] r);
    return $sformatf("R%0d", r);
  endfunction

  initial begin
    #(CLK_T * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: shared byte is zero after reset, seen through both snapshot high addresses
    op(OP_RD, 4'd1, 8'h00); check("R1 counter high after reset", {8'h0, bus_rdata}, 16'h0000);
    op(OP_RD, 4'd7, 8'h00); check("R1 capture high after reset", {8'h0, bus_rdata}, 16'h0000);
    check("R1 no strobes after reset", {12'h0, strobes()}, 16'h0000);
    for (int i = 0; i < NV; i++) begin
      op(VECS[i].op, VECS[i].addr, VECS[i].wd);
      if (VECS[i].op == OP_RD)
        check($sformatf("%s vec %0d rdata", rtag(VECS[i].req), i), {8'h0, bus_rdata},
              {8'h0, VECS[i].erd});
      else begin
        check($sformatf("%s vec %0d strobes", rtag(VECS[i].req), i), {12'h0, strobes()},
              {12'h0, VECS[i].ecm});
        if (VECS[i].ecm != 4'h0)
          check($sformatf("%s vec %0d word", rtag(VECS[i].req), i), wr_value, VECS[i].ewv);
      end
    end
    // R3: strobe lasts one cycle only
    op(2'd0, 4'd0, 8'h00);
    check("R3 strobe drops after write", {12'h0, strobes()}, 16'h0000);
    // R10: idle read data is zero even on a mapped address
    check("R10 idle rdata", {8'h0, bus_rdata}, 16'h0000);
    // R4: snapshot taken in the read cycle while the counter carries at that edge
    @(negedge clk) cnt_run = 1'b1;
    op(OP_RD, 4'd0, 8'h00); check("R4 running low byte", {8'h0, bus_rdata}, 16'h00FF);
    op(OP_RD, 4'd1, 8'h00); check("R4 pre-carry high byte", {8'h0, bus_rdata}, 16'h0000);
    op(OP_RD, 4'd0, 8'h00); check("R4 low byte after carry", {8'h0, bus_rdata}, 16'h0001);
    op(OP_RD, 4'd1, 8'h00); check("R4 post-carry high byte", {8'h0, bus_rdata}, 16'h0001);
    op(2'd0, 4'd0, 8'h00);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule